// File: doc/BRIEF.md
# Expected Path Trace String Loader

This block keeps the expected path trace string for one tributary in a small on-chip RAM. Software loads the string one byte at a time through a single data register. An internal write pointer picks the RAM byte and moves forward after each accepted write, so sixteen writes in a row fill the whole string. Writing a separate pointer-reset register sets the pointer back to the first byte, so a reload always starts from a known place.

A load-enable control bit protects the process. It comes up set after reset. While it is set, data writes reach the RAM, and the alarm outputs for trace mismatch and CRC7 error are forced low, together with the remote defect feedback request. A half-written string therefore cannot raise false alarms or send false feedback to the far end. When software clears the bit, data writes are dropped and the raw alarm inputs pass through to the outputs.

A downstream comparator reads the stored string through an asynchronous read port indexed by byte position. The comparison itself and the CRC7 check are outside this block; it only receives their raw results.

Top module: `traceLoader`

## Requirements
- R1: After reset, accessEnable is 1, every RAM byte reads 0, and the write pointer is at byte 0.
- R2: An accepted data write (wrSel = 2'b01) stores wrData at the current pointer position, and rdByte shows it from the next clock edge.
- R3: The pointer advances by one after each accepted data write, so sixteen consecutive writes fill bytes 0 to 15 in the order they were written.
- R4: After the write to byte 15 the pointer wraps to byte 0, so the seventeenth write overwrites byte 0 and leaves the other bytes alone.
- R5: A write with wrSel = 2'b10 returns the pointer to byte 0 whatever the state of accessEnable, and it leaves the RAM contents unchanged.
- R6: While accessEnable is 0, data writes change neither the RAM nor the pointer.
- R7: A write with wrSel = 2'b00 loads accessEnable from wrData bit 0. A write with wrSel = 2'b11 has no effect.
- R8: While accessEnable is 1, mismatchAlarm, crcAlarm and rdiRequest are all 0, whatever the values of rawMismatch and rawCrcErr.
- R9: While accessEnable is 0, mismatchAlarm follows rawMismatch, crcAlarm follows rawCrcErr, and rdiRequest is the OR of the two.
- R10: rdByte shows the RAM byte selected by rdIdx within the same cycle, for any index and in any order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Register write strobe, one write per cycle |
| wrSel | input | 2 | Register select: 00 control, 01 data, 10 pointer reset, 11 unused |
| wrData | input | 8 | Write data; bit 0 is the enable for a control write |
| rdIdx | input | 4 | Byte position for the comparator read |
| rdByte | output | 8 | Stored byte at rdIdx |
| rawMismatch | input | 1 | Raw trace mismatch result from the comparator |
| rawCrcErr | input | 1 | Raw CRC7 error result |
| accessEnable | output | 1 | Current load-enable state |
| mismatchAlarm | output | 1 | Gated trace mismatch alarm |
| crcAlarm | output | 1 | Gated CRC7 alarm |
| rdiRequest | output | 1 | Gated remote defect feedback request |

## Verification
The assertions assume that wrValid stays low while reset is held, so the first sampled strobe after reset is a real write, and that wrSel is stable whenever wrValid is high. The pointer checks use the pointer value from the cycle before, so they also assume that a pointer reset and a data write never arrive in the same cycle. The single write port makes that impossible, and the bench drives every register write for exactly one cycle, changing inputs only on falling edges. The raw alarm inputs are allowed to change freely. The bench applies every combination of them with load-enable both set and clear, so the gating is checked against inputs that are not held quiet.

// File: rtl/traceLoaderPkg.sv
package traceLoaderPkg;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'b00,
    SEL_DATA   = 2'b01,
    SEL_PTRCLR = 2'b10,
    SEL_NONE   = 2'b11
  } regSel_e;

  typedef struct packed {
    logic ramWe;
    logic ptrClr;
  } strobes_t;

endpackage

// File: rtl/traceCtrl.sv
module traceCtrl
  import traceLoaderPkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic [1:0]    wrSel,
  input  logic [DW-1:0] wrData,
  input  logic          rawMismatch,
  input  logic          rawCrcErr,
  output strobes_t      strb,
  output logic          accessEn,
  output logic          mismatchAlarm,
  output logic          crcAlarm,
  output logic          rdiRequest
);

  regSel_e selDec;
  logic    ctrlWr;

  assign selDec = regSel_e'(wrSel);
  assign ctrlWr = wrValid && (selDec == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accessEn <= 1'b1;
    end else if (ctrlWr) begin
      accessEn <= wrData[0];
    end
  end

  always_comb begin
    strb        = '0;
    strb.ramWe  = wrValid && (selDec == SEL_DATA) && accessEn;
    strb.ptrClr = wrValid && (selDec == SEL_PTRCLR);
  end

  always_comb begin
    mismatchAlarm = rawMismatch && !accessEn;
    crcAlarm      = rawCrcErr && !accessEn;
    rdiRequest    = mismatchAlarm || crcAlarm;
  end

  // R7
  en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWr |=> $stable(accessEn));

  // R7
  en_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (accessEn == $past(wrData[0])));

  // R8
  gate_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessEn |-> !(mismatchAlarm || crcAlarm || rdiRequest));

  // R9
  rdi_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdiRequest |-> (rawMismatch || rawCrcErr));

endmodule

// File: rtl/traceData.sv
module traceData
  import traceLoaderPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      strb,
  input  logic [DW-1:0] wrData,
  input  logic [PW-1:0] rdIdx,
  output logic [DW-1:0] rdByte
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr;
  logic [PW-1:0] ptrNext;

  assign ptrNext = (ptr == LAST) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strb.ptrClr) begin
      ptr <= '0;
    end else if (strb.ramWe) begin
      ptr <= ptrNext;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mem[g] <= '0;
      end else if (strb.ramWe && (ptr == PW'(g))) begin
        mem[g] <= wrData;
      end
    end
  end

  assign rdByte = mem[rdIdx];

  // R3 R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ramWe && !strb.ptrClr) |=>
      (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));

  // R5
  ptr_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ptrClr |=> (ptr == '0));

  // R6
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.ramWe || strb.ptrClr) |=> $stable(ptr));

  // R2
  ram_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ramWe |=> (mem[$past(ptr)] == $past(wrData)));

endmodule

// File: rtl/traceLoader.sv
module traceLoader
  import traceLoaderPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic [1:0]    wrSel,
  input  logic [DW-1:0] wrData,
  input  logic [PW-1:0] rdIdx,
  output logic [DW-1:0] rdByte,
  input  logic          rawMismatch,
  input  logic          rawCrcErr,
  output logic          accessEnable,
  output logic          mismatchAlarm,
  output logic          crcAlarm,
  output logic          rdiRequest
);

  strobes_t strb;

  traceCtrl #(.DW(DW)) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .wrValid      (wrValid),
    .wrSel        (wrSel),
    .wrData       (wrData),
    .rawMismatch  (rawMismatch),
    .rawCrcErr    (rawCrcErr),
    .strb         (strb),
    .accessEn     (accessEnable),
    .mismatchAlarm(mismatchAlarm),
    .crcAlarm     (crcAlarm),
    .rdiRequest   (rdiRequest)
  );

  traceData #(.DEPTH(DEPTH), .DW(DW)) i_data (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wrData(wrData),
    .rdIdx (rdIdx),
    .rdByte(rdByte)
  );

endmodule

// File: tb/test_traceLoader.sv
`timescale 1ns/1ps
module test_traceLoader;

  localparam int DEPTH = 16;
  localparam int DW    = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrValid = 1'b0;
  logic [1:0]    wrSel = 2'b00;
  logic [DW-1:0] wrData = '0;
  logic [3:0]    rdIdx = '0;
  logic [DW-1:0] rdByte;
  logic          rawMismatch = 1'b0;
  logic          rawCrcErr = 1'b0;
  logic          accessEnable, mismatchAlarm, crcAlarm, rdiRequest;

  traceLoader #(.DEPTH(DEPTH), .DW(DW)) i_traceLoader (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrSel(wrSel), .wrData(wrData),
    .rdIdx(rdIdx), .rdByte(rdByte), .rawMismatch(rawMismatch), .rawCrcErr(rawCrcErr),
    .accessEnable(accessEnable), .mismatchAlarm(mismatchAlarm), .crcAlarm(crcAlarm),
    .rdiRequest(rdiRequest)
  );

  always #4 clk = ~clk;

  typedef struct {
    int          kind;
    logic [3:0]  idx;
    logic [7:0]  expByte;
    logic        rawM;
    logic        rawC;
    logic        expEn;
    logic [2:0]  expAlm;
    string       req;
  } item_t;

  item_t      sbq[$];
  logic [7:0] expMem [DEPTH];
  int         expPtr = 0;
  logic       expEn = 1'b1;
  int         nChecks = 0;
  int         nFail = 0;
  bit         done = 0;

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        rdIdx = it.idx;
        rawMismatch = it.rawM;
        rawCrcErr = it.rawC;
        #1;
        nChecks++;
        case (it.kind)
          0: if (rdByte !== it.expByte) begin
               nFail++;
               $display("FAIL %s byte %0d actual %h expected %h", it.req, it.idx, rdByte, it.expByte);
             end
          1: if ({mismatchAlarm, crcAlarm, rdiRequest} !== it.expAlm) begin
               nFail++;
               $display("FAIL %s alarms actual %b expected %b", it.req,
                        {mismatchAlarm, crcAlarm, rdiRequest}, it.expAlm);
             end
          default: if (accessEnable !== it.expEn) begin
               nFail++;
               $display("FAIL %s accessEnable actual %b expected %b", it.req, accessEnable, it.expEn);
             end
        endcase
      end
    end
  end

  task automatic pushRead(input int idx, input string req);
    item_t it;
    it = '{kind: 0, idx: 4'(idx), expByte: expMem[idx], rawM: 1'b0, rawC: 1'b0,
           expEn: 1'b0, expAlm: 3'b000, req: req};
    sbq.push_back(it);
  endtask

  task automatic pushEn(input string req);
    item_t it;
    it = '{kind: 2, idx: 4'd0, expByte: 8'h00, rawM: 1'b0, rawC: 1'b0,
           expEn: expEn, expAlm: 3'b000, req: req};
    sbq.push_back(it);
  endtask

  task automatic pushAlarm(input logic m, input logic c, input string req);
    item_t it;
    logic gm, gc;
    gm = m & ~expEn;
    gc = c & ~expEn;
    it = '{kind: 1, idx: 4'd0, expByte: 8'h00, rawM: m, rawC: c,
           expEn: 1'b0, expAlm: {gm, gc, gm | gc}, req: req};
    sbq.push_back(it);
  endtask

  task automatic drain();
    wait (sbq.size() == 0);
    @(negedge clk);
  endtask

  // driver: one-cycle register write, updating the expectation model
  task automatic regWrite(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wrValid = 1'b1;
    wrSel   = sel;
    wrData  = d;
    @(negedge clk);
    wrValid = 1'b0;
    case (sel)
      2'b00: expEn = d[0];
      2'b01: if (expEn) begin
               expMem[expPtr] = d;
               expPtr = (expPtr + 1) % DEPTH;
             end
      2'b10: expPtr = 0;
      default: ;
    endcase
  endtask

  initial begin
    #(8ns * 200000);
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) expMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    pushEn("R1");
    for (int i = 0; i < DEPTH; i++) pushRead(i, "R1");
    drain();

    // R2 R3: fill sixteen bytes in order
    regWrite(2'b01, 8'hC3);
    pushRead(0, "R2");
    pushRead(1, "R2");
    drain();
    for (int i = 1; i < DEPTH; i++) regWrite(2'b01, 8'(8'h3C ^ (i * 7)));
    for (int i = 0; i < DEPTH; i++) pushRead(i, "R3");
    drain();

    // R10: reads in scattered order
    for (int i = 0; i < DEPTH; i++) pushRead((i * 5 + 3) % DEPTH, "R10");
    drain();

    // R4: wrap after byte 15
    regWrite(2'b01, 8'h5A);
    pushRead(0, "R4");
    pushRead(1, "R4");
    pushRead(15, "R4");
    drain();
    regWrite(2'b01, 8'hA5);
    pushRead(1, "R4");
    pushRead(2, "R4");
    drain();

    // R5: pointer reset keeps contents, next write lands at 0
    regWrite(2'b10, 8'hFF);
    for (int i = 0; i < DEPTH; i++) pushRead(i, "R5");
    drain();
    regWrite(2'b01, 8'h11);
    pushRead(0, "R5");
    pushRead(1, "R5");
    drain();

    // R7: unused select does nothing, control write clears enable
    regWrite(2'b11, 8'h00);
    pushEn("R7");
    for (int i = 0; i < 4; i++) pushRead(i, "R7");
    drain();
    regWrite(2'b00, 8'hFE);
    pushEn("R7");
    drain();

    // R6: data writes dropped while disabled
    regWrite(2'b01, 8'hEE);
    regWrite(2'b01, 8'hDD);
    for (int i = 0; i < DEPTH; i++) pushRead(i, "R6");
    drain();

    // R9: alarms pass through while disabled
    for (int c = 0; c < 4; c++) pushAlarm(c[1], c[0], "R9");
    drain();

    // R5: pointer reset works while disabled
    regWrite(2'b10, 8'h00);
    regWrite(2'b00, 8'h01);
    pushEn("R7");
    drain();
    regWrite(2'b01, 8'h77);
    pushRead(0, "R5");
    pushRead(1, "R6");
    drain();

    // R8: alarms held low while enabled
    for (int c = 0; c < 4; c++) pushAlarm(c[1], c[0], "R8");
    drain();

    // R1: reset again restores defaults
    regWrite(2'b00, 8'h00);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    expEn = 1'b1;
    expPtr = 0;
    for (int i = 0; i < DEPTH; i++) expMem[i] = 8'h00;
    pushEn("R1");
    pushRead(0, "R1");
    pushRead(9, "R1");
    drain();
    regWrite(2'b01, 8'h42);
    pushRead(0, "R1");
    drain();

    finishRun();
  end

endmodule